// File: doc/BRIEF.md
# Weighted Destination-Set Route Selector

This block chooses an output link for a packet in a network router. Every output link carries two configuration values: a bit set of the destinations that can be reached through it, and an integer cost. When a request arrives with the packet's destination bit set, the block considers only the links whose reachable set shares at least one bit with that destination. Among those, it picks the link with the lowest cost.

If two or more eligible links have the same lowest cost, the link with the lowest index wins. A cost of all ones marks a link as unusable. When no link is eligible, the block reports a miss.

The configuration table is captured while reset is held and stays frozen afterwards. The answer is registered, so a `route_req_i` strobe produces a `route_valid_o` pulse one clock later. The chosen port and the hit flag then hold until the next request.

Top module: `route_selector`

## Requirements
- R1: While reset is high and on the first cycle after it is released, `route_valid_o`, `route_hit_o` and `route_port_o` are all 0.
- R2: `route_valid_o` is high in exactly those cycles that follow a cycle where `route_req_i` was high. A request held for N cycles gives N consecutive responses.
- R3: A link is eligible only if the bitwise AND of its reachable mask and `route_dest_i` is nonzero.
- R4: Among eligible links, the response carries the index of the link with the smallest cost.
- R5: When several eligible links share the smallest cost, the lowest link index is reported.
- R6: When no link is eligible, the response has `route_hit_o` = 0 and `route_port_o` = 0. Otherwise `route_hit_o` = 1.
- R7: A link whose cost equals the all-ones value of the cost width is never eligible, even if its mask intersects the destination.
- R8: Link i's mask is bits [i*DEST_W +: DEST_W] of `cfg_mask_i`, and its cost is bits [i*WGT_W +: WGT_W] of `cfg_weight_i`. Both are captured on every clock edge where reset is high. Changes on these inputs while reset is low have no effect on later responses.
- R9: In cycles that do not follow a request, `route_hit_o` and `route_port_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the link table |
| cfg_mask_i | input | NUM_PORTS*DEST_W | Reachable-destination mask per link, captured in reset |
| cfg_weight_i | input | NUM_PORTS*WGT_W | Cost per link, captured in reset |
| route_req_i | input | 1 | Route request strobe |
| route_dest_i | input | DEST_W | Destination bit set of the packet |
| route_valid_o | output | 1 | Response pulse, one cycle after a request |
| route_hit_o | output | 1 | An eligible link was found |
| route_port_o | output | $clog2(NUM_PORTS) | Selected link index (0 on a miss) |

## Verification
A corrupted table entry, a wrong eligibility bit or a faulty comparison shows up on `route_port_o` or `route_hit_o` in the response cycle after the first request that touches that link. This happens on the very next clock after the request. A fault that makes the table track the configuration inputs after reset shows up as soon as those inputs change and a request follows. The bench therefore changes the configuration after reset and aims destinations at tie pairs, capped links and uncovered bits, with a model compared on every clock.

// File: rtl/route_sel_pkg.sv
package route_sel_pkg;

    localparam int DEF_PORTS  = 5;
    localparam int DEF_DEST_W = 16;
    localparam int DEF_WGT_W  = 8;

    // Width of an index able to address n items (at least one bit).
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Kind of the registered answer.
    typedef enum logic [1:0] {
        RESP_NONE = 2'd0,
        RESP_HIT  = 2'd1,
        RESP_MISS = 2'd2
    } resp_kind_e;

endpackage

// File: rtl/route_cfg_table.sv
module route_cfg_table #(
    parameter int NUM_PORTS = route_sel_pkg::DEF_PORTS,
    parameter int DEST_W    = route_sel_pkg::DEF_DEST_W,
    parameter int WGT_W     = route_sel_pkg::DEF_WGT_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PORTS*DEST_W-1:0] cfg_mask_i,
    input  logic [NUM_PORTS*WGT_W-1:0]  cfg_weight_i,
    output logic [NUM_PORTS*DEST_W-1:0] mask_o,
    output logic [NUM_PORTS*WGT_W-1:0]  weight_o
);

    // Table is written only while reset is held.
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_o   <= cfg_mask_i;
            weight_o <= cfg_weight_i;
        end
    end

    AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ($stable(mask_o) && $stable(weight_o))) else $error("table changed"); // R8

endmodule

// File: rtl/route_cand_gen.sv
module route_cand_gen #(
    parameter int NUM_PORTS = route_sel_pkg::DEF_PORTS,
    parameter int DEST_W    = route_sel_pkg::DEF_DEST_W,
    parameter int WGT_W     = route_sel_pkg::DEF_WGT_W
) (
    input  logic [DEST_W-1:0]           dest_i,
    input  logic [NUM_PORTS*DEST_W-1:0] mask_i,
    input  logic [NUM_PORTS*WGT_W-1:0]  weight_i,
    output logic [NUM_PORTS-1:0]        cand_o
);

    localparam logic [WGT_W-1:0] WGT_BLOCKED = {WGT_W{1'b1}};

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_link
        logic [DEST_W-1:0] overlap;
        logic              usable;
        assign overlap   = mask_i[g*DEST_W +: DEST_W] & dest_i;
        assign usable    = (weight_i[g*WGT_W +: WGT_W] != WGT_BLOCKED);
        assign cand_o[g] = (|overlap) && usable;
    end

endmodule

// File: rtl/route_min_scan.sv
module route_min_scan #(
    parameter int NUM_PORTS = route_sel_pkg::DEF_PORTS,
    parameter int WGT_W     = route_sel_pkg::DEF_WGT_W,
    localparam int PORT_W   = route_sel_pkg::idx_bits(NUM_PORTS)
) (
    input  logic [NUM_PORTS-1:0]       cand_i,
    input  logic [NUM_PORTS*WGT_W-1:0] weight_i,
    output logic                       found_o,
    output logic [PORT_W-1:0]          sel_o
);

    // One extra bit so the starting minimum exceeds every real cost.
    localparam logic [WGT_W:0] WGT_INF = {(WGT_W+1){1'b1}};

    logic [WGT_W:0] best;

    always_comb begin
        best    = WGT_INF;
        found_o = 1'b0;
        sel_o   = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (cand_i[i] && ({1'b0, weight_i[i*WGT_W +: WGT_W]} < best)) begin
                best    = {1'b0, weight_i[i*WGT_W +: WGT_W]};
                found_o = 1'b1;
                sel_o   = PORT_W'(i);
            end
        end
    end

    always_comb begin
        AST_FOUND_IFF_CAND: assert (found_o == (|cand_i)) else $error("found mismatch"); // R6
        if (found_o) begin
            AST_SEL_IS_CAND: assert (cand_i[sel_o]) else $error("picked non-candidate"); // R3
            for (int j = 0; j < NUM_PORTS; j++) begin
                if (cand_i[j]) begin
                    AST_SEL_IS_MIN: assert (weight_i[j*WGT_W +: WGT_W] >= weight_i[int'(sel_o)*WGT_W +: WGT_W]) else $error("not minimum"); // R4
                    if (j < int'(sel_o)) begin
                        AST_TIE_LOWEST: assert (weight_i[j*WGT_W +: WGT_W] > weight_i[int'(sel_o)*WGT_W +: WGT_W]) else $error("tie not lowest"); // R5
                    end
                end
            end
        end
    end

endmodule

// File: rtl/route_selector.sv
module route_selector #(
    parameter int NUM_PORTS = route_sel_pkg::DEF_PORTS,
    parameter int DEST_W    = route_sel_pkg::DEF_DEST_W,
    parameter int WGT_W     = route_sel_pkg::DEF_WGT_W,
    localparam int PORT_W   = route_sel_pkg::idx_bits(NUM_PORTS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PORTS*DEST_W-1:0] cfg_mask_i,
    input  logic [NUM_PORTS*WGT_W-1:0]  cfg_weight_i,
    input  logic                        route_req_i,
    input  logic [DEST_W-1:0]           route_dest_i,
    output logic                        route_valid_o,
    output logic                        route_hit_o,
    output logic [PORT_W-1:0]           route_port_o
);
    import route_sel_pkg::*;

    typedef struct packed {
        resp_kind_e        kind;
        logic [PORT_W-1:0] port;
    } route_resp_t;

    logic [NUM_PORTS*DEST_W-1:0] tbl_mask;
    logic [NUM_PORTS*WGT_W-1:0]  tbl_weight;
    logic [NUM_PORTS-1:0]        cand;
    logic                        found;
    logic [PORT_W-1:0]           sel;
    route_resp_t                 resp_d, resp_q;

    route_cfg_table #(.NUM_PORTS(NUM_PORTS), .DEST_W(DEST_W), .WGT_W(WGT_W)) u_table (
        .clk          (clk),
        .rst          (rst),
        .cfg_mask_i   (cfg_mask_i),
        .cfg_weight_i (cfg_weight_i),
        .mask_o       (tbl_mask),
        .weight_o     (tbl_weight)
    );

    route_cand_gen #(.NUM_PORTS(NUM_PORTS), .DEST_W(DEST_W), .WGT_W(WGT_W)) u_cand (
        .dest_i   (route_dest_i),
        .mask_i   (tbl_mask),
        .weight_i (tbl_weight),
        .cand_o   (cand)
    );

    route_min_scan #(.NUM_PORTS(NUM_PORTS), .WGT_W(WGT_W)) u_scan (
        .cand_i   (cand),
        .weight_i (tbl_weight),
        .found_o  (found),
        .sel_o    (sel)
    );

    always_comb begin
        resp_d = resp_q;
        if (route_req_i) begin
            resp_d.kind = found ? RESP_HIT : RESP_MISS;
            resp_d.port = found ? sel : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q        <= '{kind: RESP_NONE, port: '0};
            route_valid_o <= 1'b0;
        end else begin
            resp_q        <= resp_d;
            route_valid_o <= route_req_i;
        end
    end

    assign route_hit_o  = (resp_q.kind == RESP_HIT);
    assign route_port_o = resp_q.port;

    AST_REQ_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
        route_req_i |=> route_valid_o) else $error("missing response"); // R2
    AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        !route_req_i |=> !route_valid_o) else $error("spurious response"); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !route_req_i |=> ($stable(route_hit_o) && $stable(route_port_o))) else $error("output drift"); // R9
    AST_MISS_PORT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !route_hit_o |-> (route_port_o == '0)) else $error("miss port"); // R6

endmodule

// File: tb/tb_route_selector.sv
module tb_route_selector;
    localparam int NP = 5;
    localparam int DW = 16;
    localparam int WW = 8;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NP*DW-1:0] cfg_mask = '0;
    logic [NP*WW-1:0] cfg_weight = '0;
    logic route_req = 1'b0;
    logic [DW-1:0] route_dest = '0;
    logic route_valid, route_hit;
    logic [PW-1:0] route_port;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    string tag = "R1";

    // reference model state
    int ref_mask [NP];
    int ref_wgt  [NP];
    bit exp_v = 0;
    bit exp_h = 0;
    int exp_p = 0;

    route_selector #(.NUM_PORTS(NP), .DEST_W(DW), .WGT_W(WW)) dut (
        .clk(clk), .rst(rst), .cfg_mask_i(cfg_mask), .cfg_weight_i(cfg_weight),
        .route_req_i(route_req), .route_dest_i(route_dest),
        .route_valid_o(route_valid), .route_hit_o(route_hit), .route_port_o(route_port)
    );

    always #5 clk = ~clk;

    function automatic void ref_route(input int d, output bit h, output int p);
        int best;
        best = 1 << WW;
        h = 0;
        p = 0;
        for (int i = 0; i < NP; i++) begin
            if (((ref_mask[i] & d) != 0) && (ref_wgt[i] != (1 << WW) - 1) && (ref_wgt[i] < best)) begin
                best = ref_wgt[i];
                h = 1;
                p = i;
            end
        end
    endfunction

    always @(posedge clk) begin
        bit h;
        int p;
        cyc <= cyc + 1;
        if (rst) begin
            for (int i = 0; i < NP; i++) begin
                ref_mask[i] = int'(cfg_mask[i*DW +: DW]);
                ref_wgt[i]  = int'(cfg_weight[i*WW +: WW]);
            end
            exp_v <= 0; exp_h <= 0; exp_p <= 0;
        end else begin
            exp_v <= route_req;
            if (route_req) begin
                ref_route(int'(route_dest), h, p);
                exp_h <= h;
                exp_p <= p;
            end
        end
    end

    // Compare against the model every cycle, away from the active edge.
    always @(negedge clk) begin
        checks++;
        if (route_valid !== exp_v || route_hit !== exp_h || int'(route_port) !== exp_p) begin
            failures++;
            $display("FAIL %s model: valid=%0d hit=%0d port=%0d expected valid=%0d hit=%0d port=%0d",
                     tag, route_valid, route_hit, route_port, exp_v, exp_h, exp_p);
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic set_link(input int i, input int m, input int w);
        cfg_mask[i*DW +: DW]   = DW'(m);
        cfg_weight[i*WW +: WW] = WW'(w);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        route_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Direct check with a hand-derived expectation; response sampled one cycle later.
    task automatic probe(input int d, input bit eh, input int ep, input string t);
        tag = t;
        route_req = 1'b1;
        route_dest = DW'(d);
        @(negedge clk);
        route_req = 1'b0;
        checks++;
        if (route_valid !== 1'b1 || route_hit !== eh || int'(route_port) !== ep) begin
            failures++;
            $display("FAIL %s direct dest=%h: valid=%0d hit=%0d port=%0d expected valid=1 hit=%0d port=%0d",
                     t, d, route_valid, route_hit, route_port, eh, ep);
        end
    endtask

    initial begin
        set_link(0, 'h000F, 10);
        set_link(1, 'h00F0, 5);
        set_link(2, 'h0F0F, 5);
        set_link(3, 'hF000, 255);
        set_link(4, 'hFFF0, 20);
        tag = "R1";
        repeat (3) @(negedge clk);
        checks++;
        if (route_valid !== 0 || route_hit !== 0 || route_port !== 0) begin
            failures++;
            $display("FAIL R1 reset: valid=%0d hit=%0d port=%0d expected 0 0 0", route_valid, route_hit, route_port);
        end
        rst = 1'b0;
        @(negedge clk);

        probe('h0001, 1, 2, "R4");      // links 0 (10) and 2 (5)
        probe('h0010, 1, 1, "R4");      // links 1 (5) and 4 (20)
        probe('h0110, 1, 1, "R5");      // links 1 and 2 tie at 5
        probe('h0100, 1, 2, "R3");      // overlap only with 2 and 4
        probe('h8000, 1, 4, "R7");      // link 3 capped, link 4 takes it
        probe('h0000, 0, 0, "R6");      // nothing overlaps

        // R9: idle cycles keep the last answer
        tag = "R9";
        repeat (4) @(negedge clk);

        // R2: back-to-back requests
        tag = "R2";
        route_req = 1'b1;
        for (int k = 0; k < 6; k++) begin
            route_dest = DW'(1 << (k * 3));
            @(negedge clk);
        end
        route_req = 1'b0;
        repeat (2) @(negedge clk);

        // R8: configuration moved after reset must not matter
        set_link(0, 'hFFFF, 0);
        set_link(1, 'h0000, 1);
        probe('h0010, 1, 1, "R8");

        // Second table: link 3 is the only path to bit 15 but is capped
        set_link(0, 'h0003, 7);
        set_link(1, 'h000C, 7);
        set_link(2, 'h0030, 254);
        set_link(3, 'h8000, 255);
        set_link(4, 'h0FF0, 254);
        do_reset();
        @(negedge clk);
        probe('h8000, 0, 0, "R7");
        probe('h000F, 1, 0, "R5");
        probe('h0020, 1, 2, "R5");
        probe('h8001, 1, 0, "R3");

        tag = "R4";
        for (int k = 0; k < 400; k++) begin
            route_req = ($urandom % 3) != 0;
            route_dest = DW'($urandom);
            @(negedge clk);
        end
        route_req = 1'b0;
        repeat (2) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule